// File: doc/BRIEF.md
# MAC Control Frame Receive Filter

This block sorts every received Ethernet frame into one of three kinds: ordinary, pause, or some other MAC control frame. It then decides whether the frame goes on to the host DMA path. A frame parser upstream supplies the destination address, the type field, the opcode and the two bytes after the opcode. The parser also raises a one-cycle end-of-frame pulse and a flag that says whether the frame passed its CRC and length checks.

Two decisions are kept apart. Pause detection always drives the flow control logic through a strobe that carries the requested pause time. Forwarding to the host is decided separately, by two policy inputs. One policy input hides pause frames from the host. The other lets non-pause control frames through to the host. The type value that marks a control frame sits in a small register, and a write strobe reloads it.

Top module: `mcf_rx_filter`

## Requirements
- R1: A frame is a MAC control frame when two conditions hold. Its destination equals `station_addr_i` or the reserved control multicast address 01-80-C2-00-00-01. Its type equals the held control type. `class_o` reports 2'd0 for an ordinary frame, 2'd1 for a pause frame and 2'd2 for any other control frame.
- R2: A control frame whose opcode is 0x0001 is a pause frame. When it is valid, `pause_o` pulses and `pause_time_o` equals the `pause_field_i` value sampled with the end-of-frame pulse. Neither policy input affects this.
- R3: When `drop_pause_i` is 1, a valid pause frame gives `fwd_o`=0.
- R4: When `drop_pause_i` is 0, a valid pause frame gives `fwd_o`=1.
- R5: A valid control frame with any opcode other than 0x0001 gives `fwd_o` equal to `pass_ctrl_i`.
- R6: A valid frame that is not a control frame always gives `fwd_o`=1, whatever the policy inputs are.
- R7: A frame with `frame_ok_i`=0 gives `fwd_o`=0 and `pause_o`=0, and `dec_valid_o` is still 1.
- R8: `dec_valid_o` is high for exactly the cycle after each cycle in which `eof_i` is high. `fwd_o` and `pause_o` are 0 in every cycle in which `dec_valid_o` is 0.
- R9: After reset, the held control type is 0x8808 and all outputs are 0. A cycle with `ctl_type_we_i`=1 loads `ctl_type_i`, and the new value applies to frames whose end-of-frame pulse comes in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eof_i | input | 1 | End-of-frame pulse; the header inputs are sampled in this cycle |
| frame_ok_i | input | 1 | Frame passed the CRC and length checks |
| dst_addr_i | input | 48 | Destination address, first octet in the top byte |
| type_i | input | 16 | Type/length field |
| opcode_i | input | 16 | Control opcode |
| pause_field_i | input | 16 | The two bytes after the opcode |
| station_addr_i | input | 48 | Own station address |
| ctl_type_we_i | input | 1 | Load strobe for the control type register |
| ctl_type_i | input | 16 | New control type value |
| drop_pause_i | input | 1 | Hide pause frames from the host |
| pass_ctrl_i | input | 1 | Forward non-pause control frames |
| dec_valid_o | output | 1 | A decision is presented in this cycle |
| fwd_o | output | 1 | Forward the frame to the host |
| pause_o | output | 1 | Pause frame detected |
| pause_time_o | output | 16 | Requested pause time |
| class_o | output | 2 | Frame kind: 0 ordinary, 1 pause, 2 other control |

## Verification
Faults in the address comparators or the control type register appear as a wrong `class_o` and `fwd_o` on the very next decision. If such a fault is masked by the policy inputs, it shows as a missing or extra `pause_o`. A corrupted type register also shows up after a reload. A frame carrying the old type is then still taken as control, and a frame carrying the new type is passed as ordinary. The scoreboard catches this one cycle after the end-of-frame pulse. Any decision that arrives out of step with `eof_i` shows as an unexpected or missing `dec_valid_o` in the same cycle.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_PAUSE = 2'd1,
    CLS_CTRL  = 2'd2
  } frm_cls_e;

  localparam logic [47:0] CTRL_MCAST    = 48'h0180C2000001;
  localparam logic [15:0] PAUSE_OPCODE  = 16'h0001;
  localparam logic [15:0] CTL_TYPE_DEF  = 16'h8808;
endpackage

// File: rtl/mcf_addr_match.sv
module mcf_addr_match #(
  parameter int ADDR_W = 48,
  parameter logic [ADDR_W-1:0] MCAST = '0
) (
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] station_i,
  output logic              hit_o
);
  localparam int NB = ADDR_W / 8;

  logic [NB-1:0] st_eq, mc_eq;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign st_eq[b] = dst_i[b*8 +: 8] == station_i[b*8 +: 8];
    assign mc_eq[b] = dst_i[b*8 +: 8] == MCAST[b*8 +: 8];
  end

  assign hit_o = (&st_eq) | (&mc_eq);
endmodule

// File: rtl/mcf_classify.sv
module mcf_classify
  import mcf_pkg::*;
#(
  parameter int TYPE_W = 16,
  parameter int OPC_W  = 16,
  parameter logic [OPC_W-1:0] PAUSE_OPC = '0
) (
  input  logic              addr_hit_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [TYPE_W-1:0] ctl_type_i,
  input  logic [OPC_W-1:0]  opcode_i,
  output frm_cls_e          cls_o
);
  always_comb begin
    cls_o = CLS_PLAIN;
    if (addr_hit_i && (type_i == ctl_type_i))
      cls_o = (opcode_i == PAUSE_OPC) ? CLS_PAUSE : CLS_CTRL;
  end
endmodule

// File: rtl/mcf_policy.sv
module mcf_policy
  import mcf_pkg::*;
(
  input  frm_cls_e cls_i,
  input  logic     ok_i,
  input  logic     drop_pause_i,
  input  logic     pass_ctrl_i,
  output logic     fwd_o,
  output logic     pause_o
);
  // pause detection is independent of forwarding policy
  assign pause_o = ok_i && (cls_i == CLS_PAUSE);

  always_comb begin
    unique case (cls_i)
      CLS_PAUSE: fwd_o = ok_i && !drop_pause_i;
      CLS_CTRL:  fwd_o = ok_i && pass_ctrl_i;
      default:   fwd_o = ok_i;
    endcase
  end
endmodule

// File: rtl/mcf_rx_filter.sv
module mcf_rx_filter
  import mcf_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int TYPE_W = 16,
  parameter int OPC_W  = 16,
  parameter int TIME_W = 16,
  parameter logic [TYPE_W-1:0] CTL_TYPE_RST = CTL_TYPE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eof_i,
  input  logic              frame_ok_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [TIME_W-1:0] pause_field_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              ctl_type_we_i,
  input  logic [TYPE_W-1:0] ctl_type_i,
  input  logic              drop_pause_i,
  input  logic              pass_ctrl_i,
  output logic              dec_valid_o,
  output logic              fwd_o,
  output logic              pause_o,
  output logic [TIME_W-1:0] pause_time_o,
  output logic [1:0]        class_o
);
  localparam logic [ADDR_W-1:0] MCAST = ADDR_W'(CTRL_MCAST);
  localparam logic [OPC_W-1:0]  POPC  = OPC_W'(PAUSE_OPCODE);

  logic [TYPE_W-1:0] ctl_type_q;
  logic              addr_hit;
  frm_cls_e          cls;
  logic              fwd_d, pause_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ctl_type_q <= CTL_TYPE_RST;
    else if (ctl_type_we_i) ctl_type_q <= ctl_type_i;
  end

  mcf_addr_match #(.ADDR_W(ADDR_W), .MCAST(MCAST)) i_addr (
    .dst_i     (dst_addr_i),
    .station_i (station_addr_i),
    .hit_o     (addr_hit)
  );

  mcf_classify #(.TYPE_W(TYPE_W), .OPC_W(OPC_W), .PAUSE_OPC(POPC)) i_cls (
    .addr_hit_i (addr_hit),
    .type_i     (type_i),
    .ctl_type_i (ctl_type_q),
    .opcode_i   (opcode_i),
    .cls_o      (cls)
  );

  mcf_policy i_pol (
    .cls_i        (cls),
    .ok_i         (frame_ok_i),
    .drop_pause_i (drop_pause_i),
    .pass_ctrl_i  (pass_ctrl_i),
    .fwd_o        (fwd_d),
    .pause_o      (pause_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o  <= 1'b0;
      fwd_o        <= 1'b0;
      pause_o      <= 1'b0;
      pause_time_o <= '0;
      class_o      <= 2'd0;
    end else begin
      dec_valid_o <= eof_i;
      fwd_o       <= eof_i && fwd_d;
      pause_o     <= eof_i && pause_d;
      if (eof_i) begin
        class_o <= cls;
        if (pause_d) pause_time_o <= pause_field_i;
      end
    end
  end
endmodule

// File: rtl/mcf_rx_filter_chk.sv
module mcf_rx_filter_chk #(
  parameter int TYPE_W = 16,
  parameter int TIME_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              eof_i,
  input logic              frame_ok_i,
  input logic [TYPE_W-1:0] type_i,
  input logic [TYPE_W-1:0] ctl_type_q,
  input logic [TIME_W-1:0] pause_field_i,
  input logic              dec_valid_o,
  input logic              fwd_o,
  input logic              pause_o,
  input logic [TIME_W-1:0] pause_time_o,
  input logic [1:0]        class_o
);
  // R8
  dec_follows_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i |=> dec_valid_o);
  // R8
  no_stray_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eof_i |=> !dec_valid_o);
  // R8
  quiet_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> (!fwd_o && !pause_o));
  // R7
  bad_frame_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_i && !frame_ok_i) |=> (!fwd_o && !pause_o));
  // R2
  pause_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> (pause_time_o == $past(pause_field_i)));
  // R2
  pause_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> (class_o == 2'd1));
  // R1
  type_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_i && (type_i != ctl_type_q)) |=> (class_o == 2'd0));
  // R6
  plain_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_i && frame_ok_i && (type_i != ctl_type_q)) |=> fwd_o);
endmodule

bind mcf_rx_filter mcf_rx_filter_chk #(.TYPE_W(TYPE_W), .TIME_W(TIME_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .eof_i         (eof_i),
  .frame_ok_i    (frame_ok_i),
  .type_i        (type_i),
  .ctl_type_q    (ctl_type_q),
  .pause_field_i (pause_field_i),
  .dec_valid_o   (dec_valid_o),
  .fwd_o         (fwd_o),
  .pause_o       (pause_o),
  .pause_time_o  (pause_time_o),
  .class_o       (class_o)
);

// File: tb/test_mcf_rx_filter.sv
module test_mcf_rx_filter;
  localparam logic [47:0] STA = 48'h02AABBCCDDEE;
  localparam logic [47:0] MC  = 48'h0180C2000001;

  typedef struct packed {
    logic        fwd;
    logic        pause;
    logic [15:0] ptime;
    logic [1:0]  cls;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        eof = 1'b0, ok = 1'b0, we = 1'b0, dp = 1'b0, pc = 1'b0;
  logic [47:0] dst = '0;
  logic [15:0] typ = '0, opc = '0, pf = '0, ctl_in = '0;
  logic        dv, fwd, pause;
  logic [15:0] ptime;
  logic [1:0]  cls;

  int total = 0, bad = 0;
  logic [15:0] ctl_m = 16'h8808;
  exp_t q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  mcf_rx_filter i_mcf_rx_filter (
    .clk_i(clk), .rst_ni(rst_n), .eof_i(eof), .frame_ok_i(ok),
    .dst_addr_i(dst), .type_i(typ), .opcode_i(opc), .pause_field_i(pf),
    .station_addr_i(STA), .ctl_type_we_i(we), .ctl_type_i(ctl_in),
    .drop_pause_i(dp), .pass_ctrl_i(pc),
    .dec_valid_o(dv), .fwd_o(fwd), .pause_o(pause),
    .pause_time_o(ptime), .class_o(cls)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [47:0] d, input logic [15:0] t,
                                 input logic [15:0] o, input logic [15:0] p,
                                 input logic k, input logic dpv, input logic pcv);
    exp_t e;
    logic ctl;
    ctl = ((d == STA) || (d == MC)) && (t == ctl_m);
    e.cls = !ctl ? 2'd0 : (o == 16'h0001) ? 2'd1 : 2'd2;
    e.pause = k && (e.cls == 2'd1);
    e.ptime = e.pause ? p : 16'h0;
    e.fwd = k && ((e.cls == 2'd0) || (e.cls == 2'd1 && !dpv) || (e.cls == 2'd2 && pcv));
    return e;
  endfunction

  // drive at negedge, result appears after next posedge
  task automatic send(input string r, input logic [47:0] d, input logic [15:0] t,
                      input logic [15:0] o, input logic [15:0] p,
                      input logic k, input logic dpv, input logic pcv);
    @(negedge clk);
    dst = d; typ = t; opc = o; pf = p; ok = k; dp = dpv; pc = pcv; eof = 1'b1;
    q.push_back(model(d, t, o, p, k, dpv, pcv));
    tag_q.push_back(r);
  endtask

  task automatic idle();
    @(negedge clk);
    eof = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (dv) begin
        if (q.size() == 0) check("R8 unexpected decision", 1, 0);
        else begin
          exp_t e;
          string r;
          e = q.pop_front();
          r = tag_q.pop_front();
          check({r, " fwd"}, 32'(fwd), 32'(e.fwd));
          check({r, " pause"}, 32'(pause), 32'(e.pause));
          check({r, " class"}, 32'(cls), 32'(e.cls));
          if (e.pause) check({r, " time"}, 32'(ptime), 32'(e.ptime));
        end
      end else begin
        check("R8 idle fwd/pause", {30'd0, fwd, pause}, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset dec_valid", 32'(dv), 0);
    check("R9 reset fwd/pause", {30'd0, fwd, pause}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    send("R6 plain ip", STA, 16'h0800, 16'h0001, 16'h1234, 1, 1, 0);
    send("R4 pause mcast keep", MC, 16'h8808, 16'h0001, 16'h00FF, 1, 0, 0);
    send("R3 pause mcast drop", MC, 16'h8808, 16'h0001, 16'hBEEF, 1, 1, 0);
    send("R3 pause station drop", STA, 16'h8808, 16'h0001, 16'hFFFF, 1, 1, 1);
    send("R4 pause station keep", STA, 16'h8808, 16'h0001, 16'h0000, 1, 0, 1);
    send("R5 ctrl blocked", MC, 16'h8808, 16'h0002, 16'h5555, 1, 0, 0);
    send("R5 ctrl passed", STA, 16'h8808, 16'h0003, 16'h5555, 1, 1, 1);
    send("R1 foreign dst", 48'h0180C2000002, 16'h8808, 16'h0001, 16'h7777, 1, 1, 0);
    send("R1 near station", STA ^ 48'h1, 16'h8808, 16'h0001, 16'h7777, 1, 1, 0);
    send("R7 bad pause", MC, 16'h8808, 16'h0001, 16'h1111, 0, 0, 1);
    send("R7 bad plain", STA, 16'h0800, 16'h0000, 16'h0, 0, 0, 1);
    idle();
    idle();
    // R9 reload type
    @(negedge clk);
    we = 1'b1; ctl_in = 16'h88AA;
    @(negedge clk);
    we = 1'b0;
    ctl_m = 16'h88AA;
    send("R9 old type plain", MC, 16'h8808, 16'h0001, 16'h2222, 1, 1, 0);
    send("R9 new type pause", MC, 16'h88AA, 16'h0001, 16'h3333, 1, 0, 0);
    send("R9 new type ctrl", STA, 16'h88AA, 16'h0100, 16'h3333, 1, 0, 0);
    idle();
    repeat (3) @(negedge clk);
    check("R8 queue drained", 32'(q.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule